// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block gathers eight interrupt request lines, ranks them in fixed nested order and presents one interrupt output to a processor. Software reaches it over an 8-bit register bus with a write strobe, a read strobe and a 2-bit address. Address 0 is the control port and address 1 the auxiliary port; these two carry both the bring-up word sequence and the runtime commands. Address 2 holds the per-input trigger register. Address 3 reads as zero and ignores writes.

Bring-up starts with a control-port word that has bit 4 set. That word records the trigger mode, whether a cascade word will follow, and whether a mode word will follow. The auxiliary-port writes that come next are consumed in order: the vector base, then the optional cascade word, then the optional mode word. After the last of these, auxiliary writes load the mask.

The controller then raises its output whenever an unmasked request outranks everything already in service. A one-cycle acknowledge pulse moves the winning request into service, and while the output is high the vector output shows the base plus the winner's number. Software retires service bits with an end-of-interrupt command. It picks which of the request and in-service registers a control-port read returns with a read-select command.

The sequencing FSM has five states. ST_UNINIT is left only by a start word. ST_WAIT_BASE takes the base word and goes to ST_WAIT_CASC when cascaded, else to ST_WAIT_MODE when a mode word is expected, else to ST_RUN. ST_WAIT_CASC goes to ST_WAIT_MODE or ST_RUN. ST_WAIT_MODE goes to ST_RUN. A start word in any state goes to ST_WAIT_BASE.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset int_out is 0, the mask (read at address 1) is 8'hFF and a control-port read returns the request register.
- R2: A control write with bit 4 set restarts bring-up, clears the in-service register and resets read-select to requests. int_out stays 0 until bring-up completes. Bit 1 = 0 means a cascade word follows the base word, and bit 0 = 1 means a mode word follows last.
- R3: While int_out is 1, vector equals the base word plus the winning input number (mod 256).
- R4: Once bring-up is complete, an auxiliary write loads the mask and an auxiliary read returns it. A mask bit of 1 blocks that input.
- R5: A control write of exactly 8'h20 clears the highest-priority set in-service bit. Other control writes with bits 4 and 3 both zero leave the in-service register unchanged.
- R6: A control write with bit 4 = 0 and bit 3 = 1 is read-select. Low bits 2'b11 select the in-service register for control reads, 2'b10 selects the request register, and other low bits change nothing.
- R7: Address 2 is the trigger register, where 1 means a level input. Bits 0, 1 and 2 always read 0.
- R8: Priority is fixed with input 0 highest. int_out is 1 only when the best unmasked request has a lower number than every in-service bit.
- R9: An edge input latches a rising edge and holds it until that input is acknowledged. A level input (trigger bit set, or bit 3 of the start word set) follows its pin.
- R10: An acknowledge while int_out is 1 sets the winner's in-service bit. For an edge input it also clears the latched request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | 0 control, 1 auxiliary, 2 trigger register |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; rdata is 0 when low |
| bus_rdata | output | 8 | Read data |
| irq_in | input | 8 | Request pins |
| int_out | output | 1 | Interrupt to processor |
| int_ack | input | 1 | Single-cycle acknowledge |
| vector | output | 8 | Vector for the current winner |

## Verification
The priority path is swept over every one of the 256 request patterns, each under three masks (none, alternating bits, upper half), with level triggering. The expected output and vector are computed from the lowest unmasked set bit, which separates priority-order errors from mask-polarity errors. Nested acknowledge and end-of-interrupt sequences check that lower-priority requests are held off while higher ones break through. Single pulses on edge inputs and dropped pins on level inputs show the difference between latched and followed requests. Restarting bring-up from each of its variants shows whether the optional words are consumed or taken as mask loads.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NUM_IN = 8;
    localparam int DW     = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int AW     = 2;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_AUX  = 2'd1;
    localparam logic [AW-1:0] ADDR_TRIG = 2'd2;

    localparam logic [DW-1:0] CMD_NS_EOI = 8'h20;
    localparam logic [NUM_IN-1:0] FIXED_EDGE = 8'h07;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE,
        ST_RUN
    } cfg_state_e;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NUM_IN,
    parameter logic [N-1:0] EDGE_ONLY = FIXED_EDGE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic          ready,
    output logic          start_pulse,
    output logic          eoi_pulse,
    output logic          show_isr,
    output logic          all_level,
    output logic [W-1:0]  base,
    output logic [N-1:0]  mask,
    output logic [N-1:0]  trig
);
    cfg_state_e state_q, state_d;
    logic cascaded_q, need_mode_q;
    logic ctrl_wr, aux_wr, ocw3_wr;

    assign ctrl_wr     = wr_en && (addr == ADDR_CTRL);
    assign aux_wr      = wr_en && (addr == ADDR_AUX);
    assign start_pulse = ctrl_wr && wdata[4];
    assign ready       = (state_q == ST_RUN);
    assign eoi_pulse   = ready && ctrl_wr && (wdata == CMD_NS_EOI);
    assign ocw3_wr     = ready && ctrl_wr && !wdata[4] && wdata[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNINIT:    state_d = ST_UNINIT;
            ST_WAIT_BASE: if (aux_wr)
                              state_d = cascaded_q  ? ST_WAIT_CASC :
                                        need_mode_q ? ST_WAIT_MODE : ST_RUN;
            ST_WAIT_CASC: if (aux_wr)
                              state_d = need_mode_q ? ST_WAIT_MODE : ST_RUN;
            ST_WAIT_MODE: if (aux_wr) state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_UNINIT;
        endcase
        if (start_pulse) state_d = ST_WAIT_BASE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cascaded_q  <= 1'b0;
            need_mode_q <= 1'b0;
            all_level   <= 1'b0;
            base        <= '0;
            mask        <= '1;
            trig        <= '0;
            show_isr    <= 1'b0;
        end else begin
            if (start_pulse) begin
                cascaded_q  <= ~wdata[1];
                need_mode_q <= wdata[0];
                all_level   <= wdata[3];
                show_isr    <= 1'b0;
            end
            if (aux_wr && state_q == ST_WAIT_BASE) base <= wdata;
            if (aux_wr && ready) mask <= wdata[N-1:0];
            if (wr_en && addr == ADDR_TRIG) trig <= wdata[N-1:0] & ~EDGE_ONLY;
            if (ocw3_wr && wdata[1:0] == 2'b11) show_isr <= 1'b1;
            if (ocw3_wr && wdata[1:0] == 2'b10) show_isr <= 1'b0;
        end
    end
endmodule

// File: rtl/pic8_req.sv
module pic8_req
    import pic8_pkg::*;
#(
    parameter int N = NUM_IN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] level_sel,
    input  logic [N-1:0] clr,
    input  logic         flush,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q, latch_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i]  <= 1'b0;
                latch_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= pins[i];
                if (flush || level_sel[i])
                    latch_q[i] <= 1'b0;
                else
                    latch_q[i] <= (latch_q[i] && !clr[i]) || (pins[i] && !prev_q[i]);
            end
        end
        assign irr[i] = level_sel[i] ? pins[i] : latch_q[i];
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
#(
    parameter int N  = NUM_IN,
    parameter int IW = IDX_W
) (
    input  logic          ready,
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  isr,
    output logic          want,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  win_oh,
    output logic [N-1:0]  isr_top_oh
);
    logic [N-1:0]  pend;
    logic          pend_any, isr_any;
    logic [IW-1:0] isr_idx;

    assign pend = irr & ~mask;

    always_comb begin
        win_idx  = '0;
        pend_any = 1'b0;
        isr_idx  = '0;
        isr_any  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_idx  = IW'(i);
                pend_any = 1'b1;
            end
            if (isr[i]) begin
                isr_idx = IW'(i);
                isr_any = 1'b1;
            end
        end
    end

    assign want       = ready && pend_any && (!isr_any || win_idx < isr_idx);
    assign win_oh     = pend_any ? (N'(1) << win_idx) : '0;
    assign isr_top_oh = isr_any  ? (N'(1) << isr_idx) : '0;
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int W  = DW,
    parameter int N  = NUM_IN,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [W-1:0]  bus_rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_out,
    input  logic          int_ack,
    output logic [W-1:0]  vector
);
    logic          ready, start_pulse, eoi_pulse, show_isr, all_level;
    logic [W-1:0]  base;
    logic [N-1:0]  mask, trig, irr, isr_q, win_oh, isr_top_oh, ack_clr;
    logic [IW-1:0] win_idx;
    logic          take;

    pic8_cfg #(.W(W), .N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .ready(ready), .start_pulse(start_pulse),
        .eoi_pulse(eoi_pulse), .show_isr(show_isr), .all_level(all_level),
        .base(base), .mask(mask), .trig(trig)
    );

    assign take    = int_ack && int_out;
    assign ack_clr = take ? win_oh : '0;

    pic8_req #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .pins(irq_in),
        .level_sel(trig | {N{all_level}}), .clr(ack_clr),
        .flush(start_pulse), .irr(irr)
    );

    pic8_prio #(.N(N), .IW(IW)) u_prio (
        .ready(ready), .irr(irr), .mask(mask), .isr(isr_q),
        .want(int_out), .win_idx(win_idx), .win_oh(win_oh),
        .isr_top_oh(isr_top_oh)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           isr_q <= '0;
        else if (start_pulse) isr_q <= '0;
        else                  isr_q <= (isr_q & ~(eoi_pulse ? isr_top_oh : '0)) | ack_clr;
    end

    assign vector = int_out ? base + W'(win_idx) : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                ADDR_CTRL: bus_rdata = W'(show_isr ? isr_q : irr);
                ADDR_AUX:  bus_rdata = W'(mask);
                ADDR_TRIG: bus_rdata = W'(trig);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pic8_checker.sv
module pic8_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ready,
    input logic         int_out,
    input logic         take,
    input logic         eoi_pulse,
    input logic         start_pulse,
    input logic [N-1:0] irr,
    input logic [N-1:0] mask,
    input logic [N-1:0] isr_q,
    input logic [N-1:0] trig
);
    p_quiet_in_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    p_masked_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0));

    p_eoi_retires_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !take && !start_pulse && isr_q != '0)
        |=> $countones(isr_q) + 1 == $past($countones(isr_q)));

    p_low_lines_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig[2:0] == 3'b000);

    p_ack_adds_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !eoi_pulse && !start_pulse)
        |=> $countones(isr_q) == $past($countones(isr_q)) + 1);
endmodule

bind pic8_ctrl pic8_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .int_out(int_out),
    .take(take), .eoi_pulse(eoi_pulse), .start_pulse(start_pulse),
    .irr(irr), .mask(mask), .isr_q(isr_q), .trig(trig)
);

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vector;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pic8_ctrl dut (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 int_out", {7'b0, int_out}, 8'h00);
        rd(2'd1, d); check("R1 mask", d, 8'hFF);
        rd(2'd0, d); check("R1 ctrl read", d, 8'h00);

        // R2 cascaded bring-up with mode word, level triggered
        irq_in = 8'h01;
        wr(2'd0, 8'h19);
        wr(2'd1, 8'h40);
        step(); check("R2 quiet after base", {7'b0, int_out}, 8'h00);
        wr(2'd1, 8'h04);
        step(); check("R2 quiet after cascade", {7'b0, int_out}, 8'h00);
        rd(2'd1, d); check("R2 cascade word not mask", d, 8'hFF);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R4 mask load", d, 8'h00);
        irq_in = 8'h00;

        // R3 R4 R8 sweep over all patterns and three masks
        for (int mi = 0; mi < 3; mi++) begin
            logic [7:0] m;
            m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h55 : 8'hF0;
            wr(2'd1, m);
            for (int p = 0; p < 256; p++) begin
                logic [7:0] pend;
                int lo;
                @(negedge clk);
                irq_in = 8'(p);
                #1;
                pend = 8'(p) & ~m;
                lo = -1;
                for (int b = 7; b >= 0; b--) if (pend[b]) lo = b;
                check("R8 int_out", {7'b0, int_out}, (lo >= 0) ? 8'h01 : 8'h00);
                if (lo >= 0) check("R3 vector", vector, 8'h40 + 8'(lo));
                rd(2'd0, d); check("R6 default request read", d, 8'(p));
            end
        end
        wr(2'd1, 8'h00);

        // R10 R8 R5 R6 nesting
        irq_in = 8'h90; step();
        check("R3 vector bit4", vector, 8'h44);
        ack(); step();
        check("R8 held off by own level", {7'b0, int_out}, 8'h00);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); check("R10 isr after ack", d, 8'h10);
        irq_in = 8'h94; step();
        check("R8 higher breaks through", {7'b0, int_out}, 8'h01);
        check("R3 vector bit2", vector, 8'h42);
        ack();
        rd(2'd0, d); check("R10 nested isr", d, 8'h14);
        wr(2'd0, 8'h60);
        rd(2'd0, d); check("R5 other command ignored", d, 8'h14);
        wr(2'd0, 8'h08);
        rd(2'd0, d); check("R6 low bits 00 keep select", d, 8'h14);
        wr(2'd0, 8'h20);
        rd(2'd0, d); check("R5 eoi clears top", d, 8'h10);
        wr(2'd0, 8'h20);
        rd(2'd0, d); check("R5 eoi clears last", d, 8'h00);
        wr(2'd0, 8'h0A);
        rd(2'd0, d); check("R6 back to requests", d, 8'h94);
        irq_in = 8'h00;

        // R2 R7 R9 single mode with mode word, edge triggered
        wr(2'd0, 8'h13);
        wr(2'd1, 8'h08);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R2 single mode mask", d, 8'h00);
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R7 low lines edge", d, 8'hF8);
        wr(2'd2, 8'h00);
        @(negedge clk); irq_in = 8'h08;
        @(negedge clk); irq_in = 8'h00;
        step();
        check("R9 edge latched", {7'b0, int_out}, 8'h01);
        check("R3 edge vector", vector, 8'h0B);
        ack(); step();
        check("R10 edge cleared on ack", {7'b0, int_out}, 8'h00);
        wr(2'd0, 8'h20);
        irq_in = 8'h08; step(); step();
        wr(2'd0, 8'h20);
        ack(); step();
        check("R9 no retrigger while held", {7'b0, int_out}, 8'h00);
        wr(2'd0, 8'h20);
        irq_in = 8'h00;
        wr(2'd2, 8'h20);
        irq_in = 8'h20; step();
        check("R9 level asserts", {7'b0, int_out}, 8'h01);
        irq_in = 8'h00; step();
        check("R9 level drop", {7'b0, int_out}, 8'h00);

        // R2 restart mid-service, single mode without mode word
        irq_in = 8'h20; step();
        ack();
        wr(2'd0, 8'h1A);
        step(); check("R2 quiet after restart", {7'b0, int_out}, 8'h00);
        wr(2'd1, 8'h80);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R2 short sequence mask", d, 8'h00);
        rd(2'd0, d); check("R2 select reset to requests", d, 8'h20);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); check("R2 isr cleared", d, 8'h00);
        check("R3 restart vector", vector, 8'h85);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule